// File: doc/BRIEF.md
# Multi-format serial audio port

This block is the slave side of a stereo serial audio link. It runs entirely on an external bit clock and word-select line. Three playback lanes and one auxiliary lane are turned into parallel 24-bit left/right words. One capture stream is serialized from parallel 24-bit words. A 2-bit format select sets the input framing to one of four choices: 20-bit LSB-justified, 24-bit LSB-justified, 24-bit MSB-justified or I2S. The same select sets the output framing, which is either MSB-justified or I2S.

The receive side samples on the rising edge of the bit clock. It finds word-select transitions and counts bit periods from each one. The format decides which bits of each half-frame form the word. When a stereo frame is complete, all four lanes present their left and right words together, and one strobe marks the update.

The transmit side drives on the falling edge of the bit clock. It follows the same word-select line and picks its payload with a loop select. When the loop select is low it sends the parallel capture words. When it is high it sends the words last received on the auxiliary lane, re-timed into the output framing. Word select must be settled before the falling edge that begins a bit period.

Top module: `sap_port`

## Requirements
- R1: With `fmt_sel` = 00, each input word is the last 20 bits of its half-frame before the next word-select transition, MSB first. The word is sign-extended from bit 19 to 24 bits on the parallel outputs.
- R2: With `fmt_sel` = 01, each input word is the last 24 bits of its half-frame before the next word-select transition. Earlier bits of the half-frame are ignored.
- R3: With `fmt_sel` = 10, the input word is bit periods 0 to 23 counted from the transition, and later bits are ignored. A 16-bit word sent with zero-filled low bits arrives with those bits zero.
- R4: With `fmt_sel` = 11, the input word is bit periods 1 to 24 after the transition, and word select low marks the left channel.
- R5: With `fmt_sel` 00, 01 or 10, word select high marks the left channel and low marks the right channel.
- R6: `frame_valid` is high for exactly one bit-clock cycle per stereo frame. It rises in the first bit period of a left half, after the right half has ended. All lane outputs change only in that cycle. No strobe is given until a complete left half and a complete right half have been seen after reset.
- R7: Serial output is MSB first and changes on the falling bit-clock edge. With `fmt_sel` 00 to 10 the MSB is in bit period 0 of each half-frame. With `fmt_sel` = 11 the MSB is in bit period 1. All periods beyond the 24-bit word are driven low.
- R8: With `loop_aux` low, the output frame carries `cap_left` and `cap_right` as sampled at the falling edge that begins its left half.
- R9: With `loop_aux` high, output frame k carries the auxiliary words received in input frame k-2. Both output frames sent before the second auxiliary frame completes after reset carry zero.
- R10: Reset is synchronous and active high. It clears all parallel outputs, `frame_valid` and `ser_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | External serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ws | input | 1 | Word select, marks channel halves |
| fmt_sel | input | 2 | Framing format select |
| loop_aux | input | 1 | Output source: 0 capture words, 1 auxiliary lane |
| play_din | input | NUM_PLAY | Serial playback inputs |
| aux_din | input | 1 | Serial auxiliary input |
| cap_left | input | 24 | Capture word, left channel |
| cap_right | input | 24 | Capture word, right channel |
| play_left | output | NUM_PLAY*24 | Left words of the playback lanes, lane 0 lowest |
| play_right | output | NUM_PLAY*24 | Right words of the playback lanes, lane 0 lowest |
| aux_left | output | 24 | Left word of the auxiliary lane |
| aux_right | output | 24 | Right word of the auxiliary lane |
| frame_valid | output | 1 | One-cycle strobe per completed stereo frame |
| ser_out | output | 1 | Serial capture output |

## Verification
The bench drives ones into every bit position outside the format's window. A receiver that picks the window from the wrong end, or that is off by one period in I2S, therefore returns corrupted words rather than passing by luck. Negative 20-bit words catch a missing sign extension. Zero-filled 16-bit words in MSB-justified mode catch a receiver that shifts short words. The count of strobes in each run catches a port that strobes on the partial half-frame seen after reset, or once per half. In loop-back runs every output bit period of every half-frame is compared. This exposes a wrong frame latency, a swapped channel polarity in I2S, and pad bits that are not held low.

// File: rtl/sap_pkg.sv
package sap_pkg;

    localparam int WORD_W  = 24;
    localparam int SHORT_W = 20;
    localparam int CNT_W   = 6;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  pos_t;

    localparam pos_t POS_WORD = pos_t'(WORD_W);

    typedef enum logic [1:0] {
        FMT_LSB20 = 2'b00,
        FMT_LSB24 = 2'b01,
        FMT_MSB24 = 2'b10,
        FMT_I2S24 = 2'b11
    } fmt_e;

    typedef struct packed {
        word_t left;
        word_t right;
    } pair_t;

    // Word-select level that denotes the left channel
    function automatic logic left_level(fmt_e f);
        return (f != FMT_I2S24);
    endfunction

    // Receive: does bit period p belong to the word?
    function automatic logic rx_in_window(fmt_e f, pos_t p);
        case (f)
            FMT_MSB24: return (p < POS_WORD);
            FMT_I2S24: return (p != '0) && (p <= POS_WORD);
            default:   return 1'b1;
        endcase
    endfunction

    // Receive: form the parallel word from the shift register
    function automatic word_t rx_extract(fmt_e f, word_t sh);
        if (f == FMT_LSB20)
            return {{(WORD_W-SHORT_W){sh[SHORT_W-1]}}, sh[SHORT_W-1:0]};
        return sh;
    endfunction

    // Transmit: bit driven in period p of a half-frame carrying w
    function automatic logic tx_bit(fmt_e f, pos_t p, word_t w);
        word_t t;
        if (f == FMT_I2S24) begin
            if (p == '0 || p > POS_WORD) return 1'b0;
            t = w << (p - 1'b1);
        end else begin
            if (p >= POS_WORD) return 1'b0;
            t = w << p;
        end
        return t[WORD_W-1];
    endfunction

endpackage

// File: rtl/sap_frame_ctl.sv
module sap_frame_ctl
    import sap_pkg::*;
(
    input  logic bit_clk,
    input  logic rst,
    input  logic ws,
    input  fmt_e fmt,
    output logic edge_det,
    output pos_t pos,
    output logic fin_left,
    output logic commit,
    output logic frame_valid
);

    logic primed;
    logic ws_q;
    logic full;
    logic left_good;
    pos_t cnt;

    always_comb begin
        edge_det = primed && (ws != ws_q);
        if (edge_det)
            pos = '0;
        else if (cnt == '1)
            pos = cnt;
        else
            pos = cnt + 1'b1;
        fin_left = (ws_q == left_level(fmt));
        commit   = edge_det && full && !fin_left && left_good;
    end

    always_ff @(posedge bit_clk) begin
        if (rst) begin
            primed      <= 1'b0;
            ws_q        <= 1'b0;
            full        <= 1'b0;
            left_good   <= 1'b0;
            cnt         <= '1;
            frame_valid <= 1'b0;
        end else begin
            primed      <= 1'b1;
            ws_q        <= ws;
            cnt         <= pos;
            frame_valid <= commit;
            if (edge_det) begin
                full <= 1'b1;
                if (full && fin_left)
                    left_good <= 1'b1;
            end
        end
    end

    assert_single_strobe_R6: assert property (@(posedge bit_clk) disable iff (rst)
        frame_valid |=> !frame_valid);

    assert_strobe_at_start_R6: assert property (@(posedge bit_clk) disable iff (rst)
        frame_valid |-> (cnt == '0));

endmodule

// File: rtl/sap_rx_lane.sv
module sap_rx_lane
    import sap_pkg::*;
(
    input  logic  bit_clk,
    input  logic  rst,
    input  logic  sd,
    input  fmt_e  fmt,
    input  logic  edge_det,
    input  logic  fin_left,
    input  logic  commit,
    input  pos_t  pos,
    output pair_t pair_o
);

    word_t sh;
    word_t hold_l;

    always_ff @(posedge bit_clk) begin
        if (rst) begin
            sh     <= '0;
            hold_l <= '0;
            pair_o <= '0;
        end else begin
            if (edge_det && fin_left)
                hold_l <= rx_extract(fmt, sh);
            if (commit) begin
                pair_o.left  <= hold_l;
                pair_o.right <= rx_extract(fmt, sh);
            end
            if (rx_in_window(fmt, pos))
                sh <= {sh[WORD_W-2:0], sd};
        end
    end

endmodule

// File: rtl/sap_tx.sv
module sap_tx
    import sap_pkg::*;
(
    input  logic  bit_clk,
    input  logic  rst,
    input  logic  ws,
    input  fmt_e  fmt,
    input  pair_t src,
    output logic  ser_out
);

    logic  ws_q;
    pos_t  tcnt;
    word_t tx_l;
    word_t tx_r;
    logic  tedge;
    logic  is_left;
    pos_t  tpos;
    word_t cur;

    always_comb begin
        tedge   = (ws != ws_q);
        is_left = (ws == left_level(fmt));
        if (tedge)
            tpos = '0;
        else if (tcnt == '1)
            tpos = tcnt;
        else
            tpos = tcnt + 1'b1;
        if (is_left)
            cur = tedge ? src.left : tx_l;
        else
            cur = tx_r;
    end

    always_ff @(negedge bit_clk) begin
        if (rst) begin
            ws_q    <= 1'b0;
            tcnt    <= '1;
            tx_l    <= '0;
            tx_r    <= '0;
            ser_out <= 1'b0;
        end else begin
            ws_q    <= ws;
            tcnt    <= tpos;
            ser_out <= tx_bit(fmt, tpos, cur);
            if (tedge && is_left) begin
                tx_l <= src.left;
                tx_r <= src.right;
            end
        end
    end

    assert_pad_low_R7: assert property (@(negedge bit_clk) disable iff (rst)
        (tcnt > POS_WORD) |-> !ser_out);

endmodule

// File: rtl/sap_port.sv
module sap_port
    import sap_pkg::*;
#(
    parameter int NUM_PLAY = 3
) (
    input  logic                     bit_clk,
    input  logic                     rst,
    input  logic                     ws,
    input  logic [1:0]               fmt_sel,
    input  logic                     loop_aux,
    input  logic [NUM_PLAY-1:0]      play_din,
    input  logic                     aux_din,
    input  logic [WORD_W-1:0]        cap_left,
    input  logic [WORD_W-1:0]        cap_right,
    output logic [NUM_PLAY*WORD_W-1:0] play_left,
    output logic [NUM_PLAY*WORD_W-1:0] play_right,
    output logic [WORD_W-1:0]        aux_left,
    output logic [WORD_W-1:0]        aux_right,
    output logic                     frame_valid,
    output logic                     ser_out
);

    localparam int NUM_LANES = NUM_PLAY + 1;
    localparam int AUX_LANE  = NUM_PLAY;

    fmt_e  fmt;
    logic  edge_det;
    logic  fin_left;
    logic  commit;
    pos_t  pos;
    pair_t src;
    pair_t lane_pair [NUM_LANES];
    logic [NUM_LANES-1:0] lane_sd;

    assign fmt     = fmt_e'(fmt_sel);
    assign lane_sd = {aux_din, play_din};

    sap_frame_ctl u_ctl (
        .bit_clk     (bit_clk),
        .rst         (rst),
        .ws          (ws),
        .fmt         (fmt),
        .edge_det    (edge_det),
        .pos         (pos),
        .fin_left    (fin_left),
        .commit      (commit),
        .frame_valid (frame_valid)
    );

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        sap_rx_lane u_lane (
            .bit_clk  (bit_clk),
            .rst      (rst),
            .sd       (lane_sd[i]),
            .fmt      (fmt),
            .edge_det (edge_det),
            .fin_left (fin_left),
            .commit   (commit),
            .pos      (pos),
            .pair_o   (lane_pair[i])
        );
    end

    for (genvar i = 0; i < NUM_PLAY; i++) begin : g_flat
        assign play_left[i*WORD_W +: WORD_W]  = lane_pair[i].left;
        assign play_right[i*WORD_W +: WORD_W] = lane_pair[i].right;
    end

    assign aux_left  = lane_pair[AUX_LANE].left;
    assign aux_right = lane_pair[AUX_LANE].right;

    always_comb begin
        if (loop_aux)
            src = lane_pair[AUX_LANE];
        else
            src = '{left: cap_left, right: cap_right};
    end

    sap_tx u_tx (
        .bit_clk (bit_clk),
        .rst     (rst),
        .ws      (ws),
        .fmt     (fmt),
        .src     (src),
        .ser_out (ser_out)
    );

    assert_hold_R6: assert property (@(posedge bit_clk) disable iff (rst)
        !frame_valid |-> ($stable(play_left) && $stable(play_right)
                          && $stable(aux_left) && $stable(aux_right)));

    assert_sign_ext_R1: assert property (@(posedge bit_clk) disable iff (rst)
        (frame_valid && fmt_sel == 2'b00) |->
            ($countones(play_left[WORD_W-1:SHORT_W-1]) == 0 ||
             $countones(play_left[WORD_W-1:SHORT_W-1]) == WORD_W-SHORT_W+1));

endmodule

// File: tb/sap_port_test.sv
module sap_port_test;
    import sap_pkg::*;

    localparam int NP   = 3;
    localparam int NL   = NP + 1;
    localparam int NF   = 4;
    localparam int HALF = 32;
    localparam int NV   = 7;

    // {fmt, loop_aux, seed}
    localparam logic [26:0] VEC [NV] = '{
        {2'd0, 1'b0, 24'h13579B},
        {2'd1, 1'b0, 24'h2468AC},
        {2'd2, 1'b0, 24'h0F1E2D},
        {2'd3, 1'b0, 24'h5A5A33},
        {2'd2, 1'b1, 24'h777123},
        {2'd3, 1'b1, 24'h0C0FFE},
        {2'd0, 1'b1, 24'h3BADF0}
    };

    logic bit_clk = 1'b0;
    logic rst = 1'b1;
    logic ws = 1'b0;
    logic [1:0] fmt_sel = 2'b00;
    logic loop_aux = 1'b0;
    logic [NP-1:0] play_din = '0;
    logic aux_din = 1'b0;
    logic [23:0] cap_left = '0;
    logic [23:0] cap_right = '0;
    logic [NP*24-1:0] play_left;
    logic [NP*24-1:0] play_right;
    logic [23:0] aux_left;
    logic [23:0] aux_right;
    logic frame_valid;
    logic ser_out;

    int checks = 0;
    int errors = 0;
    int n_got = 0;

    logic [23:0] sent [NL][NF+1][2];
    logic [23:0] capw [NF+1][2];
    logic [23:0] got  [NL][NF+1][2];
    logic [31:0] slot [NF+1][2];

    int pf, ph, pp;
    bit have_prev;

    sap_port #(.NUM_PLAY(NP)) uut (
        .bit_clk(bit_clk), .rst(rst), .ws(ws), .fmt_sel(fmt_sel),
        .loop_aux(loop_aux), .play_din(play_din), .aux_din(aux_din),
        .cap_left(cap_left), .cap_right(cap_right),
        .play_left(play_left), .play_right(play_right),
        .aux_left(aux_left), .aux_right(aux_right),
        .frame_valid(frame_valid), .ser_out(ser_out)
    );

    always #10 bit_clk = ~bit_clk;

    always @(negedge bit_clk) begin
        if (!rst && frame_valid) begin
            if (n_got <= NF) begin
                for (int l = 0; l < NL; l++) begin
                    got[l][n_got][0] = (l < NP) ? play_left[l*24 +: 24] : aux_left;
                    got[l][n_got][1] = (l < NP) ? play_right[l*24 +: 24] : aux_right;
                end
            end
            n_got++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] gen(logic [23:0] seed, int f, int l, int h);
        logic [31:0] x;
        x = {8'h0, seed} * 32'h9E3779B1 + f * 32'h85EBCA6B + l * 32'hC2B2AE35 + h * 32'h27D4EB2F;
        x = x ^ (x >> 15);
        x = x * 32'h2C1B3C6D;
        x = x ^ (x >> 13);
        return x[23:0];
    endfunction

    function automatic logic bit_of(logic [23:0] w, int k);
        logic [23:0] t;
        t = w >> k;
        return t[0];
    endfunction

    // Bit the sender places in period p; ones outside the window
    function automatic logic in_bit(int mode, logic [23:0] w, int p);
        case (mode)
            0: return (p >= HALF-20) ? bit_of(w, HALF-1-p) : 1'b1;
            1: return (p >= HALF-24) ? bit_of(w, HALF-1-p) : 1'b1;
            2: return (p < 24) ? bit_of(w, 23-p) : 1'b1;
            default: return (p >= 1 && p <= 24) ? bit_of(w, 24-p) : 1'b1;
        endcase
    endfunction

    function automatic logic out_bit(int mode, logic [23:0] w, int p);
        if (mode == 3) return (p >= 1 && p <= 24) ? bit_of(w, 24-p) : 1'b0;
        return (p < 24) ? bit_of(w, 23-p) : 1'b0;
    endfunction

    function automatic logic [23:0] exp_rx(int mode, logic [23:0] v);
        if (mode == 0) return {{4{v[19]}}, v[19:0]};
        return v;
    endfunction

    function automatic string rx_tag(int mode);
        case (mode)
            0: return "R1 R5";
            1: return "R2 R5";
            2: return "R3 R5";
            default: return "R4";
        endcase
    endfunction

    task automatic step(int mode, int f, int h, int p);
        logic lvl;
        @(posedge bit_clk); #5;
        if (have_prev) slot[pf][ph][31-pp] = ser_out;
        lvl = (mode != 3);
        ws = (h == 0) ? lvl : ~lvl;
        for (int l = 0; l < NL; l++) begin
            if (l < NP) play_din[l] = in_bit(mode, sent[l][f][h], p);
            else aux_din = in_bit(mode, sent[l][f][h], p);
        end
        if (h == 0 && p == 0) begin
            cap_left  = capw[f][0];
            cap_right = capw[f][1];
        end
        pf = f; ph = h; pp = p;
        have_prev = 1'b1;
    endtask

    task automatic run_vec(int mode, logic sel, logic [23:0] seed);
        logic [23:0] w;
        logic [31:0] es;
        logic [23:0] el, er;
        @(posedge bit_clk); #5;
        rst = 1'b1;
        fmt_sel = mode[1:0];
        loop_aux = sel;
        ws = (mode == 3);
        play_din = '0;
        aux_din = 1'b0;
        repeat (3) @(posedge bit_clk);
        #5;
        chk(frame_valid == 1'b0 && ser_out == 1'b0 && play_left == '0 && play_right == '0
            && aux_left == '0 && aux_right == '0, "R10 reset clears outputs",
            {40'h0, aux_left}, 64'h0);
        for (int f = 0; f <= NF; f++) begin
            for (int h = 0; h < 2; h++) begin
                for (int l = 0; l < NL; l++) begin
                    w = gen(seed, f, l, h);
                    if (mode == 0) w[23:20] = 4'h0;
                    if (mode == 2 && l == 1) w[7:0] = 8'h00;
                    sent[l][f][h] = w;
                end
                capw[f][h] = gen(seed ^ 24'hA5A5A5, f, 9, h);
            end
        end
        n_got = 0;
        have_prev = 1'b0;
        rst = 1'b0;
        repeat (3) @(posedge bit_clk);
        for (int f = 0; f <= NF; f++)
            for (int h = 0; h < 2; h++)
                for (int p = 0; p < HALF; p++)
                    step(mode, f, h, p);
        @(posedge bit_clk); #5;
        slot[pf][ph][31-pp] = ser_out;
        have_prev = 1'b0;
        repeat (4) @(posedge bit_clk);
        #5;
        chk(n_got == NF, "R6 one strobe per complete frame", 64'(n_got), 64'(NF));
        for (int f = 0; f < NF; f++) begin
            for (int l = 0; l < NL; l++) begin
                el = exp_rx(mode, sent[l][f][0]);
                er = exp_rx(mode, sent[l][f][1]);
                chk(got[l][f][0] == el && got[l][f][1] == er, rx_tag(mode),
                    {16'h0, got[l][f][0], got[l][f][1]}, {16'h0, el, er});
            end
        end
        for (int f = 0; f <= NF; f++) begin
            for (int h = 0; h < 2; h++) begin
                if (sel) w = (f >= 2) ? exp_rx(mode, sent[NL-1][f-2][h]) : 24'h0;
                else w = capw[f][h];
                for (int p = 0; p < HALF; p++) es[31-p] = out_bit(mode, w, p);
                chk(slot[f][h] == es, sel ? "R7 R9 aux loop output" : "R7 R8 capture output",
                    {32'h0, slot[f][h]}, {32'h0, es});
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge bit_clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge bit_clk);
        #5;
        chk(frame_valid == 1'b0 && ser_out == 1'b0 && play_left == '0, "R10 initial reset",
            {63'h0, frame_valid}, 64'h0);
        for (int v = 0; v < NV; v++)
            run_vec(int'(VEC[v][26:25]), VEC[v][24], VEC[v][23:0]);
        // directed: reset mid-stream after a run must clear the parallel words
        @(posedge bit_clk); #5;
        rst = 1'b1;
        repeat (2) @(posedge bit_clk);
        #5;
        chk(play_right == '0 && aux_right == '0 && frame_valid == 1'b0, "R10 reset after traffic",
            {40'h0, aux_right}, 64'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule